// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block is the home node for a small set of memory blocks in a multiprocessor whose caches talk to it over point-to-point links. For every block it keeps a coherence state and a presence vector with one bit per cache. Caches send it read misses and write requests. The write requests cover both write misses and upgrades of a shared copy. The directory answers each request with data or a grant. When other caches hold the block, it first sends probes, and it sends them only to the caches the presence vector names. It then collects their acknowledgements before it answers.

A single transaction engine serves one request at a time. Any request that arrives while a probe round is still waiting for acknowledgements gets a retry on a separate channel. A small flop-based array holds the data of each block. When a fetch brings dirty data back from an owner, the block writes it into this array. A combinational query port reports the state and presence vector of any block, so the surrounding logic can observe the directory contents.

Top module: `coh_dir`

## Requirements
- R1: After reset every block is Uncached (query state 2'd0) with an all-zero presence vector, no response, retry or probe is valid, and block b holds data SEED+b (SEED = 16'hA000 by default).
- R2: A read on an Uncached or Shared block answers one cycle later with rsp_kind DATA (2'd1) carrying the stored data. It sends no probe, sets the requester's presence bit, and leaves the block Shared (2'd1).
- R3: A read on an Exclusive block owned by another cache sends a FETCH probe (2'd2) to the owner alone. On the owner's acknowledgement the directory writes ack_data into storage and answers DATA with that value. Both the owner's and the requester's bits end up set, and the block becomes Shared.
- R4: A write on a Shared block with other sharers sends an INV probe (2'd1) to exactly those other sharers. The directory answers only after every targeted cache has acknowledged. It answers GRANT (2'd2) if the requester was a sharer and DATA otherwise. The presence vector then holds only the requester, and the block becomes Exclusive (2'd2).
- R5: A write on an Uncached block, or on a Shared block whose only sharer is the requester, sends no probe. It answers at once, with DATA if the requester held no copy and GRANT if it did, and makes the requester the Exclusive owner.
- R6: A write on an Exclusive block owned by another cache sends a FETCH_INV probe (2'd3) to the owner. The directory stores the returned data and answers DATA with it, and the requester becomes the sole Exclusive owner.
- R7: A read or write from the current owner of an Exclusive block is answered with GRANT and changes neither state nor presence.
- R8: A request that arrives while a probe round is outstanding is answered one cycle later on the retry channel (rty_valid, rty_dst) and changes no directory state.
- R9: An Exclusive block always has exactly one presence bit set, an Uncached block has none, and a Shared block has at least one.
- R10: prb_valid is a single-cycle pulse per transaction. Its mask is a subset of the block's presence vector at the time of the request and never includes the requester.
- R11: An acknowledgement from a cache that was not probed, or that has already answered, has no effect. No response is issued until all targeted caches have acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | $clog2(NCACHE) | Requesting cache |
| req_blk | input | $clog2(NBLK) | Requested block |
| req_wr | input | 1 | 1 = write miss / upgrade, 0 = read miss |
| rsp_valid | output | 1 | Response valid |
| rsp_dst | output | $clog2(NCACHE) | Cache receiving the response |
| rsp_kind | output | 2 | 2'd1 DATA, 2'd2 GRANT |
| rsp_data | output | DW | Block data for DATA responses |
| rty_valid | output | 1 | Retry response valid |
| rty_dst | output | $clog2(NCACHE) | Cache that must retry |
| prb_valid | output | 1 | Probe valid (one cycle) |
| prb_blk | output | $clog2(NBLK) | Probed block |
| prb_kind | output | 2 | 2'd1 INV, 2'd2 FETCH, 2'd3 FETCH_INV |
| prb_mask | output | NCACHE | Caches that receive the probe |
| ack_valid | input | NCACHE | Per-cache acknowledgement |
| ack_data | input | DW | Data returned by a fetched owner |
| qry_blk | input | $clog2(NBLK) | Block to inspect |
| qry_state | output | 2 | 2'd0 Uncached, 2'd1 Shared, 2'd2 Exclusive |
| qry_pres | output | NCACHE | Presence vector of the inspected block |

## Verification
The hardest situation to reach is a partly acknowledged invalidation round. Some sharers have answered, a cache that was never probed sends a stray acknowledgement, and a second request arrives before the last acknowledgement. The bench builds a block shared by two caches and has a third cache write it. It then releases the acknowledgements one at a time, injecting the stray one and a request to an untouched block in between. At each step it checks that no response appears, that the intruder gets a retry, and that the untouched block stays Uncached. A long stretch of random requests follows, with stub caches that answer every probe. After each request the bench checks the probe mask against the presence vector it read beforehand, and checks the state/presence invariant on every block.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
   typedef enum logic [1:0] {
      DS_UNC = 2'd0,
      DS_SHR = 2'd1,
      DS_EXC = 2'd2
   } dstate_e;

   localparam logic [1:0] RSP_DATA     = 2'd1;
   localparam logic [1:0] RSP_GRANT    = 2'd2;
   localparam logic [1:0] PRB_INV      = 2'd1;
   localparam logic [1:0] PRB_FETCH    = 2'd2;
   localparam logic [1:0] PRB_FETCHINV = 2'd3;
endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
   import coh_dir_pkg::*;
#(
   parameter int NBLK   = 8,
   parameter int NCACHE = 4,
   parameter int BW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BW-1:0]     a_blk,
   output dstate_e           a_state,
   output logic [NCACHE-1:0] a_pres,
   input  logic [BW-1:0]     q_blk,
   output dstate_e           q_state,
   output logic [NCACHE-1:0] q_pres,
   input  logic              wr_en,
   input  logic [BW-1:0]     wr_blk,
   input  dstate_e           wr_state,
   input  logic [NCACHE-1:0] wr_pres
);
   dstate_e           st_q [NBLK];
   logic [NCACHE-1:0] pr_q [NBLK];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NBLK; b++) begin
            st_q[b] <= DS_UNC;
            pr_q[b] <= '0;
         end
      end else if (wr_en) begin
         st_q[wr_blk] <= wr_state;
         pr_q[wr_blk] <= wr_pres;
      end
   end

   assign a_state = st_q[a_blk];
   assign a_pres  = pr_q[a_blk];
   assign q_state = st_q[q_blk];
   assign q_pres  = pr_q[q_blk];

   AST_WR_EXCL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_state == DS_EXC) |-> ($countones(wr_pres) == 1)); // R9

   for (genvar b = 0; b < NBLK; b++) begin : g_inv
      AST_EXCL_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[b] == DS_EXC) |-> ($countones(pr_q[b]) == 1)); // R9
      AST_UNC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[b] == DS_UNC) |-> (pr_q[b] == '0)); // R9
      AST_SHR_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[b] == DS_SHR) |-> (pr_q[b] != '0)); // R9
   end
endmodule

// File: rtl/coh_dir_mem.sv
module coh_dir_mem #(
   parameter int          NBLK         = 8,
   parameter int          DW           = 16,
   parameter int          BW           = 3,
   parameter logic [DW-1:0] SEED       = '0,
   parameter bit          INIT_INDEXED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [BW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [BW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data
);
   logic [DW-1:0] init_val [NBLK];
   logic [DW-1:0] mem_q    [NBLK];

   for (genvar b = 0; b < NBLK; b++) begin : g_init
      if (INIT_INDEXED) begin : g_idx
         assign init_val[b] = SEED + DW'(b);
      end else begin : g_flat
         assign init_val[b] = SEED;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NBLK; b++) mem_q[b] <= init_val[b];
      end else if (wr_en) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/coh_dir_engine.sv
module coh_dir_engine
   import coh_dir_pkg::*;
#(
   parameter int NCACHE = 4,
   parameter int DW     = 16,
   parameter int CW     = 2,
   parameter int BW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CW-1:0]     req_src,
   input  logic [BW-1:0]     req_blk,
   input  logic              req_wr,
   input  dstate_e           cur_state,
   input  logic [NCACHE-1:0] cur_pres,
   output logic [BW-1:0]     mem_raddr,
   input  logic [DW-1:0]     mem_rdata,
   input  logic [NCACHE-1:0] ack_valid,
   input  logic [DW-1:0]     ack_data,
   output logic              sw_en,
   output logic [BW-1:0]     sw_blk,
   output dstate_e           sw_state,
   output logic [NCACHE-1:0] sw_pres,
   output logic              mw_en,
   output logic [BW-1:0]     mw_addr,
   output logic [DW-1:0]     mw_data,
   output logic              rsp_valid,
   output logic [CW-1:0]     rsp_dst,
   output logic [1:0]        rsp_kind,
   output logic [DW-1:0]     rsp_data,
   output logic              rty_valid,
   output logic [CW-1:0]     rty_dst,
   output logic              prb_valid,
   output logic [BW-1:0]     prb_blk,
   output logic [1:0]        prb_kind,
   output logic [NCACHE-1:0] prb_mask
);
   typedef enum logic {E_IDLE, E_WAIT} est_e;

   est_e              st, st_n;
   logic [NCACHE-1:0] pend, pend_n, h_pres, h_pres_n;
   logic [BW-1:0]     h_blk, h_blk_n;
   logic [CW-1:0]     h_src, h_src_n;
   logic              h_wr, h_wr_n, h_fetch, h_fetch_n;
   logic [NCACHE-1:0] src_bit, h_bit, others, pend_left;
   logic              owner_src;
   logic              o_rv, o_ry, o_pv;
   logic [CW-1:0]     o_rdst, o_ydst;
   logic [1:0]        o_rk, o_pk;
   logic [DW-1:0]     o_rd;
   logic [NCACHE-1:0] o_pm;

   assign mem_raddr = (st == E_WAIT) ? h_blk : req_blk;
   assign mw_addr   = h_blk;
   assign mw_data   = ack_data;

   always_comb begin
      src_bit = '0;
      src_bit[req_src] = 1'b1;
      h_bit = '0;
      h_bit[h_src] = 1'b1;
      owner_src = (cur_state == DS_EXC) && cur_pres[req_src];
      others    = cur_pres & ~src_bit;
      pend_left = pend & ~ack_valid;
      st_n = st;  pend_n = pend;  h_pres_n = h_pres;  h_blk_n = h_blk;
      h_src_n = h_src;  h_wr_n = h_wr;  h_fetch_n = h_fetch;
      sw_en = 1'b0;  sw_blk = req_blk;  sw_state = DS_UNC;  sw_pres = '0;
      mw_en = 1'b0;
      o_rv = 1'b0;  o_rdst = req_src;  o_rk = RSP_DATA;  o_rd = mem_rdata;
      o_ry = 1'b0;  o_ydst = req_src;
      o_pv = 1'b0;  o_pk = PRB_INV;  o_pm = '0;
      if (st == E_IDLE) begin
         if (req_valid) begin
            h_blk_n = req_blk;  h_src_n = req_src;  h_wr_n = req_wr;  h_pres_n = cur_pres;
            if (owner_src) begin
               o_rv = 1'b1;  o_rk = RSP_GRANT;
            end else if (cur_state == DS_EXC) begin
               o_pv = 1'b1;  o_pm = cur_pres;  o_pk = req_wr ? PRB_FETCHINV : PRB_FETCH;
               pend_n = cur_pres;  h_fetch_n = 1'b1;  st_n = E_WAIT;
            end else if (!req_wr) begin
               o_rv = 1'b1;  o_rk = RSP_DATA;
               sw_en = 1'b1;  sw_state = DS_SHR;  sw_pres = cur_pres | src_bit;
            end else if (others != '0) begin
               o_pv = 1'b1;  o_pm = others;  o_pk = PRB_INV;
               pend_n = others;  h_fetch_n = 1'b0;  st_n = E_WAIT;
            end else begin
               o_rv = 1'b1;  o_rk = cur_pres[req_src] ? RSP_GRANT : RSP_DATA;
               sw_en = 1'b1;  sw_state = DS_EXC;  sw_pres = src_bit;
            end
         end
      end else begin
         pend_n = pend_left;
         o_ry   = req_valid;
         if (pend_left == '0) begin
            st_n = E_IDLE;  sw_en = 1'b1;  sw_blk = h_blk;  o_rv = 1'b1;  o_rdst = h_src;
            if (h_fetch) begin
               mw_en = 1'b1;  o_rk = RSP_DATA;  o_rd = ack_data;
               sw_state = h_wr ? DS_EXC : DS_SHR;
               sw_pres  = h_wr ? h_bit : (h_pres | h_bit);
            end else begin
               sw_state = DS_EXC;  sw_pres = h_bit;
               o_rk = h_pres[h_src] ? RSP_GRANT : RSP_DATA;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= E_IDLE;  pend <= '0;  h_pres <= '0;  h_blk <= '0;  h_src <= '0;
         h_wr <= 1'b0;  h_fetch <= 1'b0;
         rsp_valid <= 1'b0;  rsp_dst <= '0;  rsp_kind <= '0;  rsp_data <= '0;
         rty_valid <= 1'b0;  rty_dst <= '0;
         prb_valid <= 1'b0;  prb_blk <= '0;  prb_kind <= '0;  prb_mask <= '0;
      end else begin
         st <= st_n;  pend <= pend_n;  h_pres <= h_pres_n;  h_blk <= h_blk_n;
         h_src <= h_src_n;  h_wr <= h_wr_n;  h_fetch <= h_fetch_n;
         rsp_valid <= o_rv;  rsp_dst <= o_rdst;  rsp_kind <= o_rk;  rsp_data <= o_rd;
         rty_valid <= o_ry;  rty_dst <= o_ydst;
         prb_valid <= o_pv;  prb_blk <= h_blk_n;  prb_kind <= o_pk;  prb_mask <= o_pm;
      end
   end

   AST_PRB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      prb_valid |=> !prb_valid); // R10
   AST_PRB_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      prb_valid |-> !prb_mask[h_src]); // R10
   AST_PEND_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_WAIT && $past(st == E_WAIT)) |-> ((pend & ~$past(pend)) == '0)); // R11
   AST_NO_EARLY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_WAIT) |-> !rsp_valid); // R11
   AST_RETRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_WAIT && req_valid) |=> rty_valid); // R8
endmodule

// File: rtl/coh_dir.sv
module coh_dir
   import coh_dir_pkg::*;
#(
   parameter int              NCACHE       = 4,
   parameter int              NBLK         = 8,
   parameter int              DW           = 16,
   parameter logic [DW-1:0]   SEED         = 16'hA000,
   parameter bit              INIT_INDEXED = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [$clog2(NCACHE)-1:0]  req_src,
   input  logic [$clog2(NBLK)-1:0]    req_blk,
   input  logic                       req_wr,
   output logic                       rsp_valid,
   output logic [$clog2(NCACHE)-1:0]  rsp_dst,
   output logic [1:0]                 rsp_kind,
   output logic [DW-1:0]              rsp_data,
   output logic                       rty_valid,
   output logic [$clog2(NCACHE)-1:0]  rty_dst,
   output logic                       prb_valid,
   output logic [$clog2(NBLK)-1:0]    prb_blk,
   output logic [1:0]                 prb_kind,
   output logic [NCACHE-1:0]          prb_mask,
   input  logic [NCACHE-1:0]          ack_valid,
   input  logic [DW-1:0]              ack_data,
   input  logic [$clog2(NBLK)-1:0]    qry_blk,
   output logic [1:0]                 qry_state,
   output logic [NCACHE-1:0]          qry_pres
);
   localparam int CW = $clog2(NCACHE);
   localparam int BW = $clog2(NBLK);

   if (NCACHE < 2 || NCACHE > 8) begin : g_chk_nc
      $error("coh_dir: NCACHE must lie in 2..8");
   end
   if (NBLK < 2 || (1 << BW) != NBLK) begin : g_chk_nb
      $error("coh_dir: NBLK must be a power of two and at least 2");
   end
   if (DW < 1) begin : g_chk_dw
      $error("coh_dir: DW must be positive");
   end

   dstate_e           a_state, q_state, sw_state;
   logic [NCACHE-1:0] a_pres, sw_pres;
   logic              sw_en, mw_en;
   logic [BW-1:0]     sw_blk, mw_addr, mem_raddr;
   logic [DW-1:0]     mw_data, mem_rdata;

   coh_dir_store #(.NBLK(NBLK), .NCACHE(NCACHE), .BW(BW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_blk(req_blk), .a_state(a_state), .a_pres(a_pres),
      .q_blk(qry_blk), .q_state(q_state), .q_pres(qry_pres),
      .wr_en(sw_en), .wr_blk(sw_blk), .wr_state(sw_state), .wr_pres(sw_pres)
   );

   coh_dir_mem #(.NBLK(NBLK), .DW(DW), .BW(BW), .SEED(SEED), .INIT_INDEXED(INIT_INDEXED)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(mem_raddr), .rd_data(mem_rdata),
      .wr_en(mw_en), .wr_addr(mw_addr), .wr_data(mw_data)
   );

   coh_dir_engine #(.NCACHE(NCACHE), .DW(DW), .CW(CW), .BW(BW)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_src(req_src), .req_blk(req_blk), .req_wr(req_wr),
      .cur_state(a_state), .cur_pres(a_pres),
      .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
      .ack_valid(ack_valid), .ack_data(ack_data),
      .sw_en(sw_en), .sw_blk(sw_blk), .sw_state(sw_state), .sw_pres(sw_pres),
      .mw_en(mw_en), .mw_addr(mw_addr), .mw_data(mw_data),
      .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
      .rty_valid(rty_valid), .rty_dst(rty_dst),
      .prb_valid(prb_valid), .prb_blk(prb_blk), .prb_kind(prb_kind), .prb_mask(prb_mask)
   );

   assign qry_state = q_state;

   AST_RSP_XOR_PRB: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && prb_valid)); // R10
endmodule

// File: tb/coh_dir_tb.sv
module coh_dir_tb;
   localparam int NC = 4, NB = 8, DW = 16, CW = 2, BW = 3;
   localparam logic [DW-1:0] SEED = 16'hA000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_wr = 1'b0;
   logic [CW-1:0] req_src = '0;
   logic [BW-1:0] req_blk = '0, qry_blk = '0;
   logic [NC-1:0] ack_valid = '0;
   logic [DW-1:0] ack_data = '0;
   logic rsp_valid, rty_valid, prb_valid;
   logic [CW-1:0] rsp_dst, rty_dst;
   logic [1:0] rsp_kind, prb_kind, qry_state;
   logic [DW-1:0] rsp_data;
   logic [BW-1:0] prb_blk;
   logic [NC-1:0] prb_mask, qry_pres;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   logic c_rv, c_yv, c_pv;
   logic [1:0] c_rk, c_pk;
   logic [DW-1:0] c_rd;
   logic [CW-1:0] c_rdst, c_ydst;
   logic [NC-1:0] c_pm;
   logic [BW-1:0] c_pb;

   always #10 clk = ~clk;

   coh_dir #(.NCACHE(NC), .NBLK(NB), .DW(DW), .SEED(SEED)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src), .req_blk(req_blk),
      .req_wr(req_wr), .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_kind(rsp_kind),
      .rsp_data(rsp_data), .rty_valid(rty_valid), .rty_dst(rty_dst), .prb_valid(prb_valid),
      .prb_blk(prb_blk), .prb_kind(prb_kind), .prb_mask(prb_mask), .ack_valid(ack_valid),
      .ack_data(ack_data), .qry_blk(qry_blk), .qry_state(qry_state), .qry_pres(qry_pres)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic capture();
      c_rv = rsp_valid; c_rdst = rsp_dst; c_rk = rsp_kind; c_rd = rsp_data;
      c_yv = rty_valid; c_ydst = rty_dst;
      c_pv = prb_valid; c_pm = prb_mask; c_pk = prb_kind; c_pb = prb_blk;
   endtask

   task automatic issue(input int src, input int blk, input bit wr);
      @(negedge clk);
      req_valid = 1'b1; req_src = CW'(src); req_blk = BW'(blk); req_wr = wr;
      @(posedge clk); #2; capture();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic ack(input logic [NC-1:0] m, input logic [DW-1:0] d);
      @(negedge clk);
      ack_valid = m; ack_data = d;
      @(posedge clk); #2; capture();
      @(negedge clk);
      ack_valid = '0;
   endtask

   task automatic look(input int blk, input string rq, input logic [1:0] st, input logic [NC-1:0] pr);
      qry_blk = BW'(blk); #1;
      chk(rq, "state", 32'(qry_state), 32'(st));
      chk(rq, "presence", 32'(qry_pres), 32'(pr));
   endtask

   task automatic t_reset();
      #2;
      chk("R1", "rsp_valid", 32'(rsp_valid), 0);
      chk("R1", "prb_valid", 32'(prb_valid), 0);
      chk("R1", "rty_valid", 32'(rty_valid), 0);
      for (int b = 0; b < NB; b++) look(b, "R1", 2'd0, '0);
      issue(1, 6, 1'b0);
      chk("R1", "initial data blk6", 32'(c_rd), 32'(SEED + 16'd6));
   endtask

   task automatic t_read_shared();
      issue(0, 1, 1'b0);
      chk("R2", "rsp", {c_rv, c_rk, 1'b0, c_rdst}, {1'b1, 2'd1, 1'b0, 2'd0});
      chk("R2", "data", 32'(c_rd), 32'(SEED + 16'd1));
      chk("R2", "no probe", 32'(c_pv), 0);
      look(1, "R2", 2'd1, 4'b0001);
      issue(2, 1, 1'b0);
      chk("R2", "second sharer data", 32'(c_rd), 32'(SEED + 16'd1));
      look(1, "R2", 2'd1, 4'b0101);
   endtask

   task automatic t_inv_round();
      issue(3, 1, 1'b1);
      chk("R4", "probe", {c_pv, c_pk, c_pm}, {1'b1, 2'd1, 4'b0101});
      chk("R10", "probe blk", 32'(c_pb), 1);
      chk("R4", "no early rsp", 32'(c_rv), 0);
      ack(4'b0010, 16'h0);
      chk("R11", "stray ack no rsp", 32'(c_rv), 0);
      ack(4'b0001, 16'h0);
      chk("R11", "partial ack no rsp", 32'(c_rv), 0);
      issue(1, 5, 1'b0);
      chk("R8", "retry", {c_yv, c_ydst}, {1'b1, 2'd1});
      chk("R8", "no rsp", 32'(c_rv), 0);
      look(5, "R8", 2'd0, '0);
      ack(4'b0100, 16'h0);
      chk("R4", "rsp", {c_rv, c_rk, 1'b0, c_rdst}, {1'b1, 2'd1, 1'b0, 2'd3});
      chk("R4", "data", 32'(c_rd), 32'(SEED + 16'd1));
      look(1, "R4", 2'd2, 4'b1000);
   endtask

   task automatic t_fetch_read();
      issue(1, 1, 1'b0);
      chk("R3", "probe", {c_pv, c_pk, c_pm}, {1'b1, 2'd2, 4'b1000});
      ack(4'b1000, 16'h5A5A);
      chk("R3", "rsp", {c_rv, c_rk, 1'b0, c_rdst}, {1'b1, 2'd1, 1'b0, 2'd1});
      chk("R3", "data", 32'(c_rd), 32'h5A5A);
      look(1, "R3", 2'd1, 4'b1010);
      issue(0, 1, 1'b0);
      chk("R3", "memory updated", 32'(c_rd), 32'h5A5A);
      look(1, "R3", 2'd1, 4'b1011);
   endtask

   task automatic t_owner();
      issue(2, 2, 1'b1);
      chk("R5", "write on uncached", {c_rv, c_rk, c_pv}, {1'b1, 2'd1, 1'b0});
      chk("R5", "data", 32'(c_rd), 32'(SEED + 16'd2));
      look(2, "R5", 2'd2, 4'b0100);
      issue(2, 2, 1'b1);
      chk("R7", "owner write", {c_rv, c_rk, c_pv}, {1'b1, 2'd2, 1'b0});
      issue(2, 2, 1'b0);
      chk("R7", "owner read", {c_rv, c_rk, c_pv}, {1'b1, 2'd2, 1'b0});
      look(2, "R7", 2'd2, 4'b0100);
   endtask

   task automatic t_upgrade_sole();
      issue(1, 4, 1'b0);
      issue(1, 4, 1'b1);
      chk("R5", "sole-sharer upgrade", {c_rv, c_rk, c_pv}, {1'b1, 2'd2, 1'b0});
      look(4, "R5", 2'd2, 4'b0010);
   endtask

   task automatic t_fetch_write();
      issue(0, 4, 1'b1);
      chk("R6", "probe", {c_pv, c_pk, c_pm}, {1'b1, 2'd3, 4'b0010});
      ack(4'b0010, 16'h1234);
      chk("R6", "rsp", {c_rv, c_rk, 1'b0, c_rdst}, {1'b1, 2'd1, 1'b0, 2'd0});
      chk("R6", "data", 32'(c_rd), 32'h1234);
      look(4, "R6", 2'd2, 4'b0001);
      issue(3, 4, 1'b0);
      chk("R3", "probe new owner", {c_pv, c_pk, c_pm}, {1'b1, 2'd2, 4'b0001});
      ack(4'b0001, 16'h4321);
      chk("R3", "data", 32'(c_rd), 32'h4321);
      look(4, "R3", 2'd1, 4'b1001);
   endtask

   task automatic t_upgrade_multi();
      issue(0, 1, 1'b1);
      chk("R4", "inv others only", {c_pv, c_pk, c_pm}, {1'b1, 2'd1, 4'b1010});
      ack(4'b1010, 16'h0);
      chk("R4", "grant to sharer", {c_rv, c_rk, 1'b0, c_rdst}, {1'b1, 2'd2, 1'b0, 2'd0});
      look(1, "R4", 2'd2, 4'b0001);
   endtask

   task automatic t_random();
      for (int i = 0; i < 300; i++) begin
         int src, blk;
         bit wr;
         logic [NC-1:0] pre;
         src = $urandom_range(0, NC - 1);
         blk = $urandom_range(0, 3);
         wr  = 1'($urandom_range(0, 1));
         qry_blk = BW'(blk); #1; pre = qry_pres;
         issue(src, blk, wr);
         if (c_pv) begin
            chk("R10", "mask within presence", 32'(c_pm & ~pre), 0);
            chk("R10", "mask excludes requester", 32'(c_pm[src]), 0);
            ack(c_pm, 16'($urandom));
         end
         chk("R11", "response after acks", {c_rv, 1'b0, c_rdst}, {1'b1, 1'b0, 2'(src)});
         for (int b = 0; b < NB; b++) begin
            qry_blk = BW'(b); #1;
            if (qry_state == 2'd2)
               chk("R9", "exclusive one bit", 32'($countones(qry_pres)), 1);
            else if (qry_state == 2'd0)
               chk("R9", "uncached empty", 32'(qry_pres), 0);
            else
               chk("R9", "shared nonempty", 32'(qry_pres != '0), 1);
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_read_shared();
      t_inv_round();
      t_fetch_read();
      t_owner();
      t_upgrade_sole();
      t_fetch_write();
      t_upgrade_multi();
      t_random();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule